// File: doc/BRIEF.md
# Checkpoint-Tagged Undo Log Buffer

This block sits next to a small array of cache blocks and keeps enough history to roll the array back to an earlier checkpoint. Each block holds data, a two-bit coherence state and the number of the checkpoint interval in which it was last changed. The first store, ownership hand-off or acquisition that touches a block in a given interval saves the block's previous contents into an undo log. Later changes to the same block in the same interval are not saved, because a rollback only ever goes back to an interval boundary.

The log is a FIFO. Each entry carries the interval number it was written in. Validating an interval frees, from the oldest end, every entry whose interval number is at or below the validated number. A recovery request names a recovery interval. The block then walks the log from its newest end, one entry per cycle. It writes each saved image back into the array until it meets an entry older than the recovery interval. While it does this it holds `busy` high and accepts no requests. Loads read the array and return the block one cycle later, and they never touch the log.

Top module: `ckpt_undo_log`

## Requirements
- R1: After a synchronous reset every block reads as data 0, state 0 (invalid), tag 0. `busy` and `rsp_valid` are low, and `req_ready` is high.
- R2: An accepted load (op 0) sets `rsp_valid` for one cycle in the next cycle. That response carries the block's data, state and tag. Loads never add a log entry, and other ops leave `rsp_valid` low.
- R3: An accepted store (op 1) to a block whose tag differs from `active_cn` first logs the old data, state and tag. It then writes `req_data`, sets the state to 3 (modified) and sets the tag to `active_cn`.
- R4: A store to a block whose tag equals `active_cn` updates the block and adds no log entry.
- R5: A transfer-out (op 2) logs like a store, then sets the state to 0 (invalid) and the tag to `active_cn`. The data is left unchanged.
- R6: An acquire (op 3) logs like a store, then writes `req_data`, `req_state` and tag `active_cn`.
- R7: After `validate_valid` with value V, every entry at the oldest end whose interval is at most V is freed. A freed entry is never unrolled, and its space becomes available again.
- R8: An accepted `recover_valid` with point P undoes every unfreed entry whose interval is at least P, newest first, one per cycle. Each undo restores the logged data, state and tag. `busy` stays high for N+1 cycles when N entries are undone, and `req_ready` is low throughout.
- R9: When the log holds LOG_DEPTH entries, `req_ready` is low for any op that would need logging. Loads and stores whose tag equals `active_cn` still see `req_ready` high.
- R10: While `busy` is high, requests, `validate_valid` and `recover_valid` have no effect.
- R11: A block logged in two intervals, and then rolled back past both, ends with its oldest saved image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_cn | input | CN_W | Number of the interval now executing |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 load, 1 store, 2 transfer-out, 3 acquire |
| req_idx | input | IDX_W | Block index |
| req_data | input | DATA_W | Write data for store or acquire |
| req_state | input | 2 | Coherence state for acquire |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DATA_W | Load data |
| rsp_state | output | 2 | Load coherence state |
| rsp_cn | output | CN_W | Load tag |
| validate_valid | input | 1 | Validate interval pulse |
| validate_cn | input | CN_W | Highest interval declared fault-free |
| recover_valid | input | 1 | Rollback request |
| recover_cn | input | CN_W | Recovery interval |
| busy | output | 1 | Rollback in progress |

## Verification
The bench aims at the tag filter. A second store in the same interval must not add an entry, and a design that logged it would stretch the rollback by one cycle, which shows up in the measured `busy` length. It rolls a block back across two intervals. A design that unrolled oldest-first would leave the intermediate value behind instead of the original. It fills the log to check that only logging ops stall, and it checks that validation really frees entries, because an unfreed entry would be restored by a later rollback. It also presents a store and a validation while a rollback is running, and a design that accepted them would leave a corrupted block or an entry that was popped too early.

// File: rtl/ulog_pkg.sv
package ulog_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_XFER  = 2'd2,
    OP_ACQ   = 2'd3
  } op_e;

  localparam int ST_W = 2;
  localparam logic [ST_W-1:0] ST_INV = 2'd0;
  localparam logic [ST_W-1:0] ST_MOD = 2'd3;
endpackage

// File: rtl/ulog_block_array.sv
module ulog_block_array #(
  parameter int NBLK   = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8,
  parameter int ST_W   = 2,
  parameter int CN_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [ST_W-1:0]   rd_state,
  output logic [CN_W-1:0]   rd_cn,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ST_W-1:0]   wr_state,
  input  logic [CN_W-1:0]   wr_cn
);
  logic [DATA_W-1:0] data_q  [NBLK];
  logic [ST_W-1:0]   state_q [NBLK];
  logic [CN_W-1:0]   tag_q   [NBLK];

  // Small array kept in registers: it is read combinationally to decide
  // logging in the same cycle as the request.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBLK; i++) begin
        data_q[i]  <= '0;
        state_q[i] <= '0;
        tag_q[i]   <= '0;
      end
    end else if (wr_en) begin
      data_q[wr_idx]  <= wr_data;
      state_q[wr_idx] <= wr_state;
      tag_q[wr_idx]   <= wr_cn;
    end
  end

  assign rd_data  = data_q[rd_idx];
  assign rd_state = state_q[rd_idx];
  assign rd_cn    = tag_q[rd_idx];
endmodule

// File: rtl/ulog_fifo.sv
module ulog_fifo #(
  parameter int PAY_W = 16,
  parameter int KEY_W = 4,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [PAY_W-1:0] push_pay,
  input  logic [KEY_W-1:0] push_key,
  input  logic             pop_head,
  input  logic             pop_tail,
  output logic [KEY_W-1:0] head_key,
  output logic [PAY_W-1:0] tail_pay,
  output logic [KEY_W-1:0] tail_key,
  output logic             full,
  output logic             empty
);
  logic [PAY_W-1:0] pay_mem [DEPTH];
  logic [KEY_W-1:0] key_mem [DEPTH];
  logic [AW:0]      head_q, tail_q, tail_m1, used;

  assign tail_m1 = tail_q - 1'b1;
  assign used    = tail_q - head_q;
  assign full    = (used == (AW+1)'(DEPTH));
  assign empty   = (used == '0);

  always_ff @(posedge clk) begin
    if (push) begin
      pay_mem[tail_q[AW-1:0]] <= push_pay;
      key_mem[tail_q[AW-1:0]] <= push_key;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (pop_head) head_q <= head_q + 1'b1;
      if (push)          tail_q <= tail_q + 1'b1;
      else if (pop_tail) tail_q <= tail_m1;
    end
  end

  assign head_key = key_mem[head_q[AW-1:0]];
  assign tail_pay = pay_mem[tail_m1[AW-1:0]];
  assign tail_key = key_mem[tail_m1[AW-1:0]];
endmodule

// File: rtl/ckpt_undo_log.sv
module ckpt_undo_log
  import ulog_pkg::*;
#(
  parameter int NBLK      = 8,
  parameter int DATA_W    = 8,
  parameter int CN_W      = 4,
  parameter int LOG_DEPTH = 8,
  localparam int IDX_W    = $clog2(NBLK),
  localparam int PAY_W    = IDX_W + ST_W + DATA_W + CN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CN_W-1:0]   active_cn,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ST_W-1:0]   req_state,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ST_W-1:0]   rsp_state,
  output logic [CN_W-1:0]   rsp_cn,
  input  logic              validate_valid,
  input  logic [CN_W-1:0]   validate_cn,
  input  logic              recover_valid,
  input  logic [CN_W-1:0]   recover_cn,
  output logic              busy
);
  op_e               op;
  logic [DATA_W-1:0] rd_data;
  logic [ST_W-1:0]   rd_state;
  logic [CN_W-1:0]   rd_cn;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [ST_W-1:0]   wr_state;
  logic [CN_W-1:0]   wr_cn;

  logic              log_push, log_pop_head, log_pop_tail, log_full, log_empty;
  logic [PAY_W-1:0]  tl_pay;
  logic [CN_W-1:0]   tl_cn, hd_cn;
  logic [IDX_W-1:0]  tl_idx;
  logic [ST_W-1:0]   tl_state;
  logic [DATA_W-1:0] tl_data;
  logic [CN_W-1:0]   tl_oldcn;

  logic              busy_q, vld_any_q;
  logic [CN_W-1:0]   rp_q, vld_q;
  logic              needs_log, accept, undo_now;

  assign op = op_e'(req_op);

  ulog_block_array #(
    .NBLK(NBLK), .IDX_W(IDX_W), .DATA_W(DATA_W), .ST_W(ST_W), .CN_W(CN_W)
  ) u_blocks (
    .clk(clk), .rst(rst),
    .rd_idx(req_idx), .rd_data(rd_data), .rd_state(rd_state), .rd_cn(rd_cn),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_state(wr_state), .wr_cn(wr_cn)
  );

  ulog_fifo #(
    .PAY_W(PAY_W), .KEY_W(CN_W), .DEPTH(LOG_DEPTH)
  ) u_log (
    .clk(clk), .rst(rst),
    .push(log_push), .push_pay({req_idx, rd_state, rd_data, rd_cn}),
    .push_key(active_cn),
    .pop_head(log_pop_head), .pop_tail(log_pop_tail),
    .head_key(hd_cn), .tail_pay(tl_pay), .tail_key(tl_cn),
    .full(log_full), .empty(log_empty)
  );

  assign {tl_idx, tl_state, tl_data, tl_oldcn} = tl_pay;

  // First modifying event of this interval on the block must save the old image.
  assign needs_log = (op != OP_LOAD) && (rd_cn != active_cn);
  assign req_ready = !busy_q && !recover_valid && !(needs_log && log_full);
  assign accept    = req_valid && req_ready;
  assign log_push  = accept && needs_log;

  // Unroll: one entry per cycle while the newest entry is not older than the point.
  assign undo_now     = busy_q && !log_empty && (tl_cn >= rp_q);
  assign log_pop_tail = undo_now;
  assign log_pop_head = !busy_q && !recover_valid && !log_empty &&
                        vld_any_q && (hd_cn <= vld_q);

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = req_idx;
    wr_data  = rd_data;
    wr_state = rd_state;
    wr_cn    = active_cn;
    if (undo_now) begin
      wr_en    = 1'b1;
      wr_idx   = tl_idx;
      wr_data  = tl_data;
      wr_state = tl_state;
      wr_cn    = tl_oldcn;
    end else if (accept) begin
      case (op)
        OP_STORE: begin
          wr_en    = 1'b1;
          wr_data  = req_data;
          wr_state = ST_MOD;
        end
        OP_XFER: begin
          wr_en    = 1'b1;
          wr_state = ST_INV;
        end
        OP_ACQ: begin
          wr_en    = 1'b1;
          wr_data  = req_data;
          wr_state = req_state;
        end
        default: wr_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      rp_q      <= '0;
      vld_q     <= '0;
      vld_any_q <= 1'b0;
    end else begin
      if (!busy_q && recover_valid) begin
        busy_q <= 1'b1;
        rp_q   <= recover_cn;
      end else if (busy_q && !undo_now) begin
        busy_q <= 1'b0;
      end
      if (!busy_q && validate_valid) begin
        vld_q     <= validate_cn;
        vld_any_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_state <= '0;
      rsp_cn    <= '0;
    end else begin
      rsp_valid <= accept && (op == OP_LOAD);
      if (accept && (op == OP_LOAD)) begin
        rsp_data  <= rd_data;
        rsp_state <= rd_state;
        rsp_cn    <= rd_cn;
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/ckpt_undo_log_chk.sv
module ckpt_undo_log_chk #(
  parameter int LOG_DEPTH = 8,
  localparam int CNT_W    = $clog2(LOG_DEPTH) + 1
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       recover_valid,
  input logic       rsp_valid,
  input logic       log_push,
  input logic       log_pop_head,
  input logic       log_pop_tail
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, log_push}
                        - {{(CNT_W-1){1'b0}}, log_pop_head}
                        - {{(CNT_W-1){1'b0}}, log_pop_tail};
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LOG_DEPTH));
  p_full_no_push_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(LOG_DEPTH)) |-> !log_push);
  p_empty_no_unroll_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> !log_pop_tail);
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!req_ready && !log_push && !log_pop_head));
  p_recover_starts_r8: assert property (@(posedge clk) disable iff (rst)
    (recover_valid && !busy) |=> busy);
  p_load_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'd0) |=> rsp_valid);
  p_load_nolog_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'd0) |-> !log_push);
  p_rsp_only_load_r2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready && req_op == 2'd0) |=> !rsp_valid);
endmodule

bind ckpt_undo_log ckpt_undo_log_chk #(.LOG_DEPTH(LOG_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .req_valid(req_valid),
  .req_ready(req_ready), .req_op(req_op), .recover_valid(recover_valid),
  .rsp_valid(rsp_valid), .log_push(log_push), .log_pop_head(log_pop_head),
  .log_pop_tail(log_pop_tail)
);

// File: tb/ckpt_undo_log_tb.sv
`timescale 1ns/1ps
module ckpt_undo_log_tb_top;
  localparam int NBLK = 8, DATA_W = 8, CN_W = 4, LOG_DEPTH = 8, IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CN_W-1:0] active_cn = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [1:0] req_state = '0;
  logic req_ready, rsp_valid, busy;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0] rsp_state;
  logic [CN_W-1:0] rsp_cn;
  logic validate_valid = 1'b0;
  logic [CN_W-1:0] validate_cn = '0;
  logic recover_valid = 1'b0;
  logic [CN_W-1:0] recover_cn = '0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ckpt_undo_log #(.NBLK(NBLK), .DATA_W(DATA_W), .CN_W(CN_W), .LOG_DEPTH(LOG_DEPTH)) dut_i (
    .clk(clk), .rst(rst), .active_cn(active_cn), .req_valid(req_valid),
    .req_op(req_op), .req_idx(req_idx), .req_data(req_data), .req_state(req_state),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_state(rsp_state), .rsp_cn(rsp_cn), .validate_valid(validate_valid),
    .validate_cn(validate_cn), .recover_valid(recover_valid),
    .recover_cn(recover_cn), .busy(busy)
  );

  // {op, idx, data, state, active, exp_data, exp_state, exp_cn}
  localparam int NV = 9;
  localparam logic [32:0] VEC [NV] = '{
    {2'd1, 3'd0, 8'hA1, 2'd0, 4'd1, 8'h00, 2'd0, 4'd0},
    {2'd0, 3'd0, 8'h00, 2'd0, 4'd1, 8'hA1, 2'd3, 4'd1},  // R3
    {2'd1, 3'd0, 8'hA2, 2'd0, 4'd1, 8'h00, 2'd0, 4'd0},
    {2'd0, 3'd0, 8'h00, 2'd0, 4'd1, 8'hA2, 2'd3, 4'd1},  // R4
    {2'd3, 3'd1, 8'hB1, 2'd1, 4'd1, 8'h00, 2'd0, 4'd0},
    {2'd0, 3'd1, 8'h00, 2'd0, 4'd1, 8'hB1, 2'd1, 4'd1},  // R6
    {2'd2, 3'd1, 8'h00, 2'd0, 4'd2, 8'h00, 2'd0, 4'd0},
    {2'd0, 3'd1, 8'h00, 2'd0, 4'd2, 8'hB1, 2'd0, 4'd2},  // R5
    {2'd0, 3'd2, 8'h00, 2'd0, 4'd2, 8'h00, 2'd0, 4'd0}   // R1
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic issue(input logic [1:0] op, input int idx, input logic [7:0] d,
                       input logic [1:0] st, input logic [3:0] acn);
    req_valid = 1'b1; req_op = op; req_idx = IDX_W'(idx);
    req_data = d; req_state = st; active_cn = acn;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load_chk(input int idx, input logic [13:0] exp, input string req);
    issue(2'd0, idx, 8'h00, 2'd0, active_cn);
    check(rsp_valid == 1'b1, req, int'(rsp_valid), 1);
    check({rsp_data, rsp_state, rsp_cn} == exp, req,
          int'({rsp_data, rsp_state, rsp_cn}), int'(exp));
  endtask

  task automatic validate(input logic [3:0] v);
    validate_valid = 1'b1; validate_cn = v;
    @(posedge clk); @(negedge clk);
    validate_valid = 1'b0;
    repeat (LOG_DEPTH + 2) @(negedge clk);
  endtask

  task automatic recover(input logic [3:0] rp, input int exp_busy, input string req);
    int n = 0;
    recover_valid = 1'b1; recover_cn = rp;
    @(posedge clk); @(negedge clk);
    recover_valid = 1'b0;
    while (busy) begin n++; @(negedge clk); end
    check(n == exp_busy, req, n, exp_busy);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(req_ready && !busy && !rsp_valid, "R1", {req_ready, busy, rsp_valid}, 3'b100);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][32:31], int'(VEC[i][30:28]), VEC[i][27:20], VEC[i][19:18], VEC[i][17:14]);
      check(rsp_valid == (VEC[i][32:31] == 2'd0), "R2", int'(rsp_valid), int'(VEC[i][32:31] == 2'd0));
      if (VEC[i][32:31] == 2'd0)
        check({rsp_data, rsp_state, rsp_cn} == VEC[i][13:0], "R3 R4 R5 R6 R1 vec",
              int'({rsp_data, rsp_state, rsp_cn}), int'(VEC[i][13:0]));
    end

    // R8: undo only the interval-2 entry, then the interval-1 entries
    recover(4'd2, 2, "R8 busy len rp2");
    load_chk(1, {8'hB1, 2'd1, 4'd1}, "R8 idx1 after rp2");
    recover(4'd1, 3, "R8 busy len rp1 (R4 no extra entry)");
    load_chk(0, {8'h00, 2'd0, 4'd0}, "R8 idx0 restored");
    load_chk(1, {8'h00, 2'd0, 4'd0}, "R8 idx1 acquire undone");

    // R11: two intervals on one block, roll back past both
    issue(2'd1, 3, 8'hC1, 2'd0, 4'd3);
    issue(2'd1, 3, 8'hC2, 2'd0, 4'd4);
    recover(4'd3, 3, "R11 busy len");
    load_chk(3, {8'h00, 2'd0, 4'd0}, "R11 oldest image");

    // R7: validated entry is freed and not unrolled
    issue(2'd1, 4, 8'hD1, 2'd0, 4'd5);
    validate(4'd5);
    issue(2'd1, 4, 8'hD2, 2'd0, 4'd6);
    recover(4'd5, 2, "R7 freed entry not unrolled");
    load_chk(4, {8'hD1, 2'd3, 4'd5}, "R7 idx4 keeps validated value");

    // R9: fill the log
    for (int i = 0; i < NBLK; i++) issue(2'd1, i, 8'h70 + 8'(i), 2'd0, 4'd7);
    req_op = 2'd1; req_idx = 3'd0; active_cn = 4'd8; #1;
    check(req_ready == 1'b0, "R9 full logging store", int'(req_ready), 0);
    req_op = 2'd2; #1;
    check(req_ready == 1'b0, "R9 full transfer", int'(req_ready), 0);
    req_op = 2'd0; #1;
    check(req_ready == 1'b1, "R9 full load", int'(req_ready), 1);
    req_op = 2'd1; active_cn = 4'd7; #1;
    check(req_ready == 1'b1, "R9 full same-tag store", int'(req_ready), 1);
    @(negedge clk);
    validate(4'd7);
    req_op = 2'd1; req_idx = 3'd0; active_cn = 4'd8; #1;
    check(req_ready == 1'b1, "R7 space freed", int'(req_ready), 1);
    @(negedge clk);
    issue(2'd1, 0, 8'h80, 2'd0, 4'd8);
    issue(2'd1, 1, 8'h81, 2'd0, 4'd8);
    issue(2'd1, 2, 8'h82, 2'd0, 4'd8);

    // R10: store and validate offered during rollback are dropped
    recover_valid = 1'b1; recover_cn = 4'd8;
    @(posedge clk); @(negedge clk);
    recover_valid = 1'b0;
    req_valid = 1'b1; req_op = 2'd1; req_idx = 3'd1; req_data = 8'hEE; active_cn = 4'd8;
    validate_valid = 1'b1; validate_cn = 4'd9;
    #1;
    check(req_ready == 1'b0, "R8 ready low while busy", int'(req_ready), 0);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; validate_valid = 1'b0;
    n = 1;
    while (busy) begin n++; @(negedge clk); end
    check(n == 4, "R8 busy len three entries", n, 4);
    load_chk(1, {8'h71, 2'd3, 4'd7}, "R10 store during busy ignored");
    load_chk(0, {8'h70, 2'd3, 4'd7}, "R8 idx0 restored");
    issue(2'd1, 5, 8'h99, 2'd0, 4'd9);
    repeat (4) @(negedge clk);
    recover(4'd9, 2, "R10 validate during busy ignored");
    load_chk(5, {8'h75, 2'd3, 4'd7}, "R10 idx5 restored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule